// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block runs the entry sequence that an 8-bit processor core performs when it starts from reset, takes a maskable interrupt, takes a non-maskable interrupt, or executes a software break. It takes over a byte-wide memory bus for the length of the sequence. It saves the return address and the status byte on a stack that lives in page one of memory. It then reads a little-endian 16-bit vector from a fixed address at the top of memory and hands the new program counter, stack pointer and status byte back to the core. At the same moment it reports how many cycles the core must charge for the entry.

The core presents its current program counter, stack pointer and status byte on the inputs. It raises one of the request lines and, when the done pulse arrives, picks up the results. The block has no knowledge of instruction decode or arithmetic. When it finishes a reset entry it asks the core to clear its data registers.

Top module: `intr_entry_seq`

## Requirements
- R1: A reset request performs no bus writes. It reads 0xFFFC (low byte) and then 0xFFFD (high byte) into the program counter, and sets the stack pointer to 0xFD. It sets the status byte to 0x20, which leaves only bit 5 set. It reports a budget of 6, and asserts clr_regs together with done.
- R2: Maskable interrupt, non-maskable interrupt and break each push three bytes in this order: program counter high byte, program counter low byte, status byte. Each write goes to address 0x0100 + SP. SP decrements by one after every push and wraps from 0x00 to 0xFF, so sp_out equals the input SP minus 3.
- R3: A maskable request, held as a level on irq, is taken only while bit 2 (interrupt disable) of status_in is 0. When that bit is 1 there is no bus access and no done pulse.
- R4: A non-maskable request is taken on a rising edge of nmi whatever the value of bit 2. A level that stays high after the entry does not start a second entry.
- R5: The non-maskable entry reads its vector from 0xFFFA and 0xFFFB. The maskable and break entries read theirs from 0xFFFE and 0xFFFF. The low byte is read first, and the program counter becomes {high, low}.
- R6: The pushed status byte is the input status with bit 2 set, and with bit 4 (break) set for a break entry and cleared for the two interrupt entries. The returned live status has bit 2 set and bit 4 cleared. All other bits are unchanged.
- R7: A break entry pushes the input program counter plus one, with a 16-bit wrap.
- R8: When requests arrive together, the priority is reset, then non-maskable, then break, then maskable.
- R9: Each bus access takes exactly one clock. Write and read strobes never overlap. done is high for exactly one cycle, the cycle after the vector high byte is read. The budget reported for the interrupt and break entries is 7.
- R10: A non-maskable rising edge that arrives while another entry is in progress is remembered. It is serviced as soon as the sequencer is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer itself |
| rst_req | input | 1 | Request a processor reset entry |
| irq | input | 1 | Maskable interrupt request, level |
| nmi | input | 1 | Non-maskable interrupt request, rising edge |
| brk_req | input | 1 | Software break request, one-cycle pulse |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 8 | Current stack pointer |
| status_in | input | 8 | Current status byte |
| bus_addr | output | 16 | Memory address |
| bus_wdata | output | 8 | Memory write data |
| bus_rdata | input | 8 | Memory read data, valid in the same cycle |
| bus_we | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| pc_out | output | 16 | Program counter after the entry |
| sp_out | output | 8 | Stack pointer after the entry |
| status_out | output | 8 | Live status after the entry |
| budget | output | 3 | Cycles to charge, valid with done |
| clr_regs | output | 1 | Clear the core's data registers, with done on reset entry |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench aims at a stack pointer of 0x01, where the third push must land at 0x01FF; a design that borrows into the page byte would write to 0x00FF instead. It starts a break at program counter 0xFFFF, which must push 0x0000; a design that dropped the increment, or pushed the wrong byte first, would show up in the first two writes. It sends all four requests at once, together with a fresh non-maskable edge. The bench expects a reset entry followed at once by the remembered non-maskable entry, so a design that lost the latched edge, or let break beat reset, would produce the wrong vector reads. It also holds a masked maskable request and a lingering high nmi level, and expects total bus silence from both; a design that ignored the mask or re-entered on a level would make writes that nothing expects.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  localparam logic [DATA_W-1:0] STACK_PAGE = 8'h01;
  localparam logic [DATA_W-1:0] SP_AFTER_RESET = 8'hFD;
  localparam logic [DATA_W-1:0] STATUS_AFTER_RESET = 8'h20;

  localparam int FLAG_I = 2;
  localparam int FLAG_B = 4;

  localparam logic [ADDR_W-1:0] VEC_NMI = 16'hFFFA;
  localparam logic [ADDR_W-1:0] VEC_RST = 16'hFFFC;
  localparam logic [ADDR_W-1:0] VEC_IRQ = 16'hFFFE;

  typedef enum logic [1:0] {
    K_RST = 2'd0,
    K_NMI = 2'd1,
    K_BRK = 2'd2,
    K_IRQ = 2'd3
  } entry_kind_e;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_PUSH_HI = 3'd1,
    S_PUSH_LO = 3'd2,
    S_PUSH_ST = 3'd3,
    S_VEC_LO  = 3'd4,
    S_VEC_HI  = 3'd5,
    S_DONE    = 3'd6
  } seq_state_e;

  function automatic logic [ADDR_W-1:0] vector_base(entry_kind_e k);
    case (k)
      K_RST:   return VEC_RST;
      K_NMI:   return VEC_NMI;
      default: return VEC_IRQ;
    endcase
  endfunction

endpackage

// File: rtl/intr_seq_arb.sv
module intr_seq_arb
  import intr_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rst_req,
  input  logic        nmi,
  input  logic        irq,
  input  logic        brk_req,
  input  logic        irq_masked,
  input  logic        accept,
  output logic        req_valid,
  output entry_kind_e req_kind
);

  logic nmi_prev_q, nmi_prev_d;
  logic nmi_pend_q, nmi_pend_d;
  logic nmi_rise;
  logic nmi_want;
  logic irq_want;

  assign nmi_rise = nmi & ~nmi_prev_q;
  assign nmi_want = nmi_pend_q | nmi_rise;
  assign irq_want = irq & ~irq_masked;

  // fixed priority select
  always_comb begin
    req_valid = 1'b1;
    req_kind  = K_IRQ;
    if (rst_req)       req_kind = K_RST;
    else if (nmi_want) req_kind = K_NMI;
    else if (brk_req)  req_kind = K_BRK;
    else if (irq_want) req_kind = K_IRQ;
    else               req_valid = 1'b0;
  end

  // edge memory for the non-maskable line
  always_comb begin
    nmi_prev_d = nmi;
    nmi_pend_d = nmi_want;
    if (accept && (req_kind == K_NMI)) nmi_pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev_q <= 1'b0;
      nmi_pend_q <= 1'b0;
    end else begin
      nmi_prev_q <= nmi_prev_d;
      nmi_pend_q <= nmi_pend_d;
    end
  end

endmodule

// File: rtl/intr_seq_fsm.sv
module intr_seq_fsm
  import intr_seq_pkg::*;
#(
  parameter int RST_BUDGET = 6,
  parameter int INT_BUDGET = 7,
  parameter int BUDGET_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  entry_kind_e       req_kind,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0] status_in,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              accept,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic              bus_rd,
  output logic [ADDR_W-1:0] pc_q,
  output logic [DATA_W-1:0] sp_q,
  output logic [DATA_W-1:0] st_q,
  output logic [BUDGET_W-1:0] budget,
  output logic              clr_regs,
  output logic              done
);

  localparam int HALF = ADDR_W / 2;

  seq_state_e        state_q, state_d;
  entry_kind_e       kind_q, kind_d;
  logic [ADDR_W-1:0] pc_d;
  logic [DATA_W-1:0] sp_d;
  logic [DATA_W-1:0] st_d;
  logic [ADDR_W-1:0] vec_lo;
  logic [ADDR_W-1:0] stack_addr;
  logic [DATA_W-1:0] pushed_status;

  assign vec_lo     = vector_base(kind_q);
  assign stack_addr = {STACK_PAGE, sp_q};

  always_comb begin
    pushed_status = st_q;
    pushed_status[FLAG_B] = (kind_q == K_BRK);
  end

  always_comb begin
    state_d   = state_q;
    kind_d    = kind_q;
    pc_d      = pc_q;
    sp_d      = sp_q;
    st_d      = st_q;
    accept    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    bus_we    = 1'b0;
    bus_rd    = 1'b0;
    budget    = '0;
    clr_regs  = 1'b0;
    done      = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          kind_d = req_kind;
          if (req_kind == K_RST) begin
            pc_d    = pc_in;
            sp_d    = SP_AFTER_RESET;
            st_d    = STATUS_AFTER_RESET;
            state_d = S_VEC_LO;
          end else begin
            pc_d = (req_kind == K_BRK) ? pc_in + 1'b1 : pc_in;
            sp_d = sp_in;
            st_d = status_in;
            st_d[FLAG_I] = 1'b1;
            st_d[FLAG_B] = 1'b0;
            state_d = S_PUSH_HI;
          end
        end
      end
      S_PUSH_HI: begin
        bus_addr  = stack_addr;
        bus_wdata = pc_q[ADDR_W-1:HALF];
        bus_we    = 1'b1;
        sp_d      = sp_q - 1'b1;
        state_d   = S_PUSH_LO;
      end
      S_PUSH_LO: begin
        bus_addr  = stack_addr;
        bus_wdata = pc_q[HALF-1:0];
        bus_we    = 1'b1;
        sp_d      = sp_q - 1'b1;
        state_d   = S_PUSH_ST;
      end
      S_PUSH_ST: begin
        bus_addr  = stack_addr;
        bus_wdata = pushed_status;
        bus_we    = 1'b1;
        sp_d      = sp_q - 1'b1;
        state_d   = S_VEC_LO;
      end
      S_VEC_LO: begin
        bus_addr = vec_lo;
        bus_rd   = 1'b1;
        pc_d     = {pc_q[ADDR_W-1:HALF], bus_rdata};
        state_d  = S_VEC_HI;
      end
      S_VEC_HI: begin
        bus_addr = vec_lo + 1'b1;
        bus_rd   = 1'b1;
        pc_d     = {bus_rdata, pc_q[HALF-1:0]};
        state_d  = S_DONE;
      end
      S_DONE: begin
        done     = 1'b1;
        clr_regs = (kind_q == K_RST);
        budget   = (kind_q == K_RST) ? BUDGET_W'(RST_BUDGET) : BUDGET_W'(INT_BUDGET);
        state_d  = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      kind_q  <= K_RST;
      pc_q    <= '0;
      sp_q    <= '0;
      st_q    <= '0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      pc_q    <= pc_d;
      sp_q    <= sp_d;
      st_q    <= st_d;
    end
  end

endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
  import intr_seq_pkg::*;
#(
  parameter int RST_BUDGET = 6,
  parameter int INT_BUDGET = 7,
  parameter int BUDGET_W   = $clog2(INT_BUDGET + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rst_req,
  input  logic                irq,
  input  logic                nmi,
  input  logic                brk_req,
  input  logic [15:0]         pc_in,
  input  logic [7:0]          sp_in,
  input  logic [7:0]          status_in,
  output logic [15:0]         bus_addr,
  output logic [7:0]          bus_wdata,
  input  logic [7:0]          bus_rdata,
  output logic                bus_we,
  output logic                bus_rd,
  output logic [15:0]         pc_out,
  output logic [7:0]          sp_out,
  output logic [7:0]          status_out,
  output logic [BUDGET_W-1:0] budget,
  output logic                clr_regs,
  output logic                done
);

  logic        req_valid;
  entry_kind_e req_kind;
  logic        accept;

  intr_seq_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_req    (rst_req),
    .nmi        (nmi),
    .irq        (irq),
    .brk_req    (brk_req),
    .irq_masked (status_in[FLAG_I]),
    .accept     (accept),
    .req_valid  (req_valid),
    .req_kind   (req_kind)
  );

  intr_seq_fsm #(
    .RST_BUDGET (RST_BUDGET),
    .INT_BUDGET (INT_BUDGET),
    .BUDGET_W   (BUDGET_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .pc_in     (pc_in),
    .sp_in     (sp_in),
    .status_in (status_in),
    .bus_rdata (bus_rdata),
    .accept    (accept),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rd    (bus_rd),
    .pc_q      (pc_out),
    .sp_q      (sp_out),
    .st_q      (status_out),
    .budget    (budget),
    .clr_regs  (clr_regs),
    .done      (done)
  );

endmodule

// File: rtl/intr_entry_seq_chk.sv
module intr_entry_seq_chk #(
  parameter int RST_BUDGET = 6,
  parameter int BUDGET_W   = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [15:0]         bus_addr,
  input logic                bus_we,
  input logic                bus_rd,
  input logic [7:0]          sp_out,
  input logic [7:0]          status_out,
  input logic [BUDGET_W-1:0] budget,
  input logic                clr_regs,
  input logic                done
);

  // R2: every write lands in the stack page
  a_r2_stack_page: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> (bus_addr[15:8] == 8'h01));

  // R2: stack pointer steps down once per push
  a_r2_sp_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> (sp_out == $past(sp_out) - 8'd1));

  // R5: reads only touch the vector area
  a_r5_vector_area: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (bus_addr[15:3] == 13'h1FFF));

  // R9: strobes exclusive, done lasts one cycle
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_rd));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: live status on completion
  a_r6_live_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr_regs) |-> (status_out[2] && !status_out[4]));

  // R1: reset entry results
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    clr_regs |-> (done && sp_out == 8'hFD && status_out == 8'h20
                  && budget == BUDGET_W'(RST_BUDGET)));

endmodule

bind intr_entry_seq intr_entry_seq_chk #(
  .RST_BUDGET (RST_BUDGET),
  .BUDGET_W   (BUDGET_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .bus_rd     (bus_rd),
  .sp_out     (sp_out),
  .status_out (status_out),
  .budget     (budget),
  .clr_regs   (clr_regs),
  .done       (done)
);

// File: tb/test_intr_entry_seq.sv
module test_intr_entry_seq;

  typedef struct packed {
    logic [15:0] a;
    logic [7:0]  d;
    logic        w;
  } bus_item_t;

  typedef struct packed {
    logic [15:0] pc;
    logic [7:0]  sp;
    logic [7:0]  st;
    logic [2:0]  bud;
    logic        clr;
  } res_item_t;

  logic clk, rst_n, rst_req, irq, nmi, brk_req;
  logic [15:0] pc_in;
  logic [7:0]  sp_in, status_in;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        bus_we, bus_rd;
  logic [15:0] pc_out;
  logic [7:0]  sp_out, status_out;
  logic [2:0]  budget;
  logic        clr_regs, done;

  int checks = 0;
  int errors = 0;
  int accesses = 0;
  int dones = 0;
  bus_item_t exp_bus[$];
  res_item_t exp_res[$];
  string tag_bus = "R2";
  string tag_res = "R5";

  intr_entry_seq i_intr_entry_seq (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] mem_rd(logic [15:0] a);
    case (a)
      16'hFFFA: return 8'h11;
      16'hFFFB: return 8'h22;
      16'hFFFC: return 8'h33;
      16'hFFFD: return 8'h44;
      16'hFFFE: return 8'h55;
      16'hFFFF: return 8'h66;
      default:  return 8'hEE;
    endcase
  endfunction
  assign bus_rdata = mem_rd(bus_addr);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // kind: 0 reset, 1 nmi, 2 brk, 3 irq
  task automatic expect_entry(int kind, logic [15:0] pc, logic [7:0] sp, logic [7:0] st);
    logic [15:0] vec;
    logic [15:0] ppc;
    logic [7:0]  live;
    logic [7:0]  pushed;
    vec = (kind == 0) ? 16'hFFFC : (kind == 1) ? 16'hFFFA : 16'hFFFE;
    if (kind != 0) begin
      ppc = (kind == 2) ? pc + 16'd1 : pc;
      live = (st | 8'h04) & ~8'h10;
      pushed = live | ((kind == 2) ? 8'h10 : 8'h00);
      exp_bus.push_back('{a: {8'h01, sp},         d: ppc[15:8], w: 1'b1});
      exp_bus.push_back('{a: {8'h01, sp - 8'd1},  d: ppc[7:0],  w: 1'b1});
      exp_bus.push_back('{a: {8'h01, sp - 8'd2},  d: pushed,    w: 1'b1});
    end
    exp_bus.push_back('{a: vec,         d: 8'h00, w: 1'b0});
    exp_bus.push_back('{a: vec + 16'd1, d: 8'h00, w: 1'b0});
    if (kind == 0)
      exp_res.push_back('{pc: {mem_rd(vec + 16'd1), mem_rd(vec)}, sp: 8'hFD, st: 8'h20, bud: 3'd6, clr: 1'b1});
    else
      exp_res.push_back('{pc: {mem_rd(vec + 16'd1), mem_rd(vec)}, sp: sp - 8'd3,
                          st: (st | 8'h04) & ~8'h10, bud: 3'd7, clr: 1'b0});
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && (bus_we || bus_rd)) begin
      accesses++;
      if (exp_bus.size() == 0) begin
        checks++; errors++;
        $display("FAIL %s unexpected access actual=%h expected=none", tag_bus, bus_addr);
      end else begin
        bus_item_t e;
        e = exp_bus.pop_front();
        check(tag_bus, {15'd0, bus_we, bus_addr}, {15'd0, e.w, e.a});
        if (e.w) check(tag_bus, {24'd0, bus_wdata}, {24'd0, e.d});
      end
    end
    if (rst_n && done) begin
      dones++;
      if (exp_res.size() == 0) begin
        checks++; errors++;
        $display("FAIL %s unexpected done actual=1 expected=0", tag_res);
      end else begin
        res_item_t r;
        r = exp_res.pop_front();
        check(tag_res, {pc_out, sp_out, status_out}, {r.pc, r.sp, r.st});
        check("R9", {28'd0, budget, clr_regs}, {28'd0, r.bud, r.clr});
      end
    end
  end

  task automatic wait_idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_done();
    int start;
    start = dones;
    while (dones == start) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int a0;
    rst_n = 1'b0; rst_req = 1'b0; irq = 1'b0; nmi = 1'b0; brk_req = 1'b0;
    pc_in = 16'h1234; sp_in = 8'h80; status_in = 8'h00;
    wait_idle(3);
    rst_n = 1'b1;
    wait_idle(1);
    check("R9 reset state", {done, bus_we, bus_rd}, 3'b000);

    // R1 reset entry
    tag_bus = "R1"; tag_res = "R1";
    expect_entry(0, pc_in, sp_in, status_in);
    rst_req = 1'b1; wait_idle(1); rst_req = 1'b0;
    wait_done(); wait_idle(2);

    // R2 R6 maskable entry, SP wraps across 0x00
    tag_bus = "R2"; tag_res = "R6";
    pc_in = 16'hA1B2; sp_in = 8'h01; status_in = 8'hC3;
    expect_entry(3, pc_in, sp_in, status_in);
    irq = 1'b1; wait_done(); irq = 1'b0; wait_idle(2);

    // R3 masked maskable request: no access
    status_in = 8'h04; a0 = accesses;
    irq = 1'b1; wait_idle(12); irq = 1'b0;
    check("R3 masked irq accesses", accesses - a0, 0);

    // R4 R5 non-maskable with I set, held high afterwards
    tag_bus = "R5"; tag_res = "R4";
    pc_in = 16'h4000; sp_in = 8'hFF; status_in = 8'h14;
    expect_entry(1, pc_in, sp_in, status_in);
    nmi = 1'b1; wait_done();
    a0 = accesses; wait_idle(12);
    check("R4 nmi level no retrigger", accesses - a0, 0);
    nmi = 1'b0; wait_idle(2);

    // R7 break with PC wrap and pushed B
    tag_bus = "R7"; tag_res = "R6";
    pc_in = 16'hFFFF; sp_in = 8'h50; status_in = 8'h01;
    expect_entry(2, pc_in, sp_in, status_in);
    brk_req = 1'b1; wait_idle(1); brk_req = 1'b0;
    wait_done(); wait_idle(2);

    // R8 R10 all at once: reset wins, latched nmi follows
    tag_bus = "R8"; tag_res = "R10";
    pc_in = 16'h0800; sp_in = 8'h30; status_in = 8'h00;
    expect_entry(0, pc_in, sp_in, status_in);
    expect_entry(1, pc_in, sp_in, status_in);
    rst_req = 1'b1; nmi = 1'b1; brk_req = 1'b1; irq = 1'b1;
    wait_idle(1);
    rst_req = 1'b0; brk_req = 1'b0; irq = 1'b0; nmi = 1'b0;
    wait_done(); wait_done(); wait_idle(2);

    // R8 break beats maskable
    tag_bus = "R8"; tag_res = "R8";
    pc_in = 16'h2222; sp_in = 8'h90; status_in = 8'h00;
    expect_entry(2, pc_in, sp_in, status_in);
    brk_req = 1'b1; irq = 1'b1; wait_idle(1);
    brk_req = 1'b0; irq = 1'b0;
    wait_done(); wait_idle(4);

    check("R9 scoreboard drained", exp_bus.size() + exp_res.size(), 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule